// File: doc/BRIEF.md
# Crosstalk Glitch Detector Output Cell

This block sits on the output side of a combinational circuit under test, one lane per circuit output. It does two things in turn. First it asks whether an output follows the input that currently carries the test square wave. For this it captures the output while the square wave is low, then compares that captured value with the live output once the square wave has gone high. A difference marks the lane as sensitized, and a per-lane mode bit holds that result. Second, it watches the output at full test-clock speed while the square wave runs. Any two consecutive samples that differ set a sticky error bit.

A toggling output is expected on a sensitized lane, so the mode bit masks it. A fault is reported only where the mode bit is 0 and the error bit is 1. That is an output that should have stayed static but produced a pulse, taken to be induced by coupling from the toggled aggressor path. The capture, update and detect strobes are clock enables on the single test clock. Only the value present at a capture edge can reach the detector.

Top module: `xtalk_glitch_cell`

## Requirements
- R1: While rst_n is low, mode_o, err_o and fault_o are all 0 on every lane.
- R2: On a clock edge with mode_le high, each lane's mode bit takes (captured value XOR live cut_out bit). It becomes 1 when they differ and 0 when they match.
- R3: On a clock edge with mode_le low, the mode bits keep their value whatever cut_out does.
- R4: On a clock edge with det_en high, mode_le low and err_clr low, a lane's error bit is set if its capture flop differs from its update flop. Once set, it stays 1 until err_clr.
- R5: err_clr high clears every error bit on the next edge, and it takes priority over a simultaneous set condition.
- R6: No error bit is set on an edge where mode_le is high.
- R7: No error bit is set on an edge where det_en is low.
- R8: fault_o of a lane is 1 exactly when its error bit is 1 and its mode bit is 0.
- R9: A pulse on cut_out that starts and ends between two clock edges leaves the error bits unchanged.
- R10: The capture flop loads cut_out on edges with cap_en high. The update flop loads the capture flop on edges with upd_en high. Lanes are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all strobes are enables on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cut_out | input | LANES | Outputs of the circuit under test, bit i to lane i |
| cap_en | input | 1 | Capture strobe: capture flop loads cut_out |
| upd_en | input | 1 | Update strobe: update flop loads capture flop |
| det_en | input | 1 | Detect strobe: error detector may set |
| mode_le | input | 1 | Mode latch enable during the sensitization check |
| err_clr | input | 1 | Synchronous clear of the error detectors |
| mode_o | output | LANES | Per-lane sensitized flag |
| err_o | output | LANES | Per-lane sticky error bit |
| fault_o | output | LANES | Per-lane fault flag (error on a non-sensitized lane) |

## Verification
The assertions take for granted that every strobe is a synchronous enable sampled on the test clock. They also assume that cut_out has settled by each rising edge, and that the detector is never armed in the same cycle as a sensitization check. The stimulus drives all inputs on falling edges. It inserts one priming cycle with det_en low at the start of each square-wave phase, so the update flop never holds a value left from an earlier phase. Glitches are modelled as one-cycle level changes across an edge. Pulses meant to be ignored are raised and dropped between edges.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;

    typedef struct packed {
        logic cap;
        logic upd;
    } samp_t;

    typedef struct packed {
        logic sens;
    } mode_t;

    typedef struct packed {
        logic hit;
    } err_t;

endpackage

// File: rtl/xtalk_sample_stage.sv
module xtalk_sample_stage
    import xtalk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cut_i,
    input  logic cap_en,
    input  logic upd_en,
    output logic live_diff_o,
    output logic seq_diff_o
);
    samp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) st_d.cap = cut_i;
        if (upd_en) st_d.upd = st_q.cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // first comparator: held sample against live output
    assign live_diff_o = st_q.cap ^ cut_i;
    // second comparator: two consecutive registered samples
    assign seq_diff_o  = st_q.cap ^ st_q.upd;

    // R10: update flop follows capture flop when strobed
    a_r10_upd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !cap_en) |=> (seq_diff_o == 1'b0));
endmodule

// File: rtl/xtalk_mode_latch.sv
module xtalk_mode_latch
    import xtalk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic diff_i,
    output logic sens_o
);
    mode_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (load_i) m_d.sens = diff_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign sens_o = m_q.sens;

    // R3: mode bit frozen outside the sensitization check
    a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(sens_o));
endmodule

// File: rtl/xtalk_err_detect.sv
module xtalk_err_detect
    import xtalk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic arm_i,
    input  logic block_i,
    input  logic diff_i,
    output logic err_o
);
    err_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (clr_i)
            e_d.hit = 1'b0;
        else if (arm_i && !block_i && diff_i)
            e_d.hit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign err_o = e_q.hit;

    // R4: sticky until cleared
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_i) |=> err_o);
    // R5: clear wins
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !err_o);
    // R6: nothing recorded during the sensitization check
    a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && block_i) |=> !err_o);
    // R7: nothing recorded while the detector is not strobed
    a_r7_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !arm_i) |=> !err_o);
endmodule

// File: rtl/xtalk_lane.sv
module xtalk_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic cut_i,
    input  logic cap_en,
    input  logic upd_en,
    input  logic det_en,
    input  logic mode_le,
    input  logic err_clr,
    output logic mode_o,
    output logic err_o,
    output logic fault_o
);
    logic live_diff, seq_diff;

    xtalk_sample_stage u_samp (
        .clk(clk), .rst_n(rst_n), .cut_i(cut_i),
        .cap_en(cap_en), .upd_en(upd_en),
        .live_diff_o(live_diff), .seq_diff_o(seq_diff)
    );

    xtalk_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .load_i(mode_le),
        .diff_i(live_diff), .sens_o(mode_o)
    );

    xtalk_err_detect u_err (
        .clk(clk), .rst_n(rst_n), .clr_i(err_clr), .arm_i(det_en),
        .block_i(mode_le), .diff_i(seq_diff), .err_o(err_o)
    );

    // R8: a sensitized lane masks its detector
    assign fault_o = err_o & ~mode_o;
endmodule

// File: rtl/xtalk_glitch_cell.sv
module xtalk_glitch_cell #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] cut_out,
    input  logic             cap_en,
    input  logic             upd_en,
    input  logic             det_en,
    input  logic             mode_le,
    input  logic             err_clr,
    output logic [LANES-1:0] mode_o,
    output logic [LANES-1:0] err_o,
    output logic [LANES-1:0] fault_o
);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        xtalk_lane u_lane (
            .clk(clk), .rst_n(rst_n), .cut_i(cut_out[i]),
            .cap_en(cap_en), .upd_en(upd_en), .det_en(det_en),
            .mode_le(mode_le), .err_clr(err_clr),
            .mode_o(mode_o[i]), .err_o(err_o[i]), .fault_o(fault_o[i])
        );
    end

    logic [LW:0] fault_cnt;
    always_comb fault_cnt = ($countones(fault_o)) & {(LW+1){1'b1}};

    // R8: a reported fault never sits on a sensitized lane
    a_r8_fault_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o & mode_o) == '0);
    // R1: outputs are quiet after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (err_o == '0 && mode_o == '0 && fault_cnt == '0));
endmodule

// File: tb/sim_xtalk_glitch_cell.sv
`timescale 1ns/100ps
module sim_xtalk_glitch_cell;
    localparam int L = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [L-1:0] cut_out = '0;
    logic cap_en = 0, upd_en = 0, det_en = 0, mode_le = 0, err_clr = 0;
    logic [L-1:0] mode_o, err_o, fault_o;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xtalk_glitch_cell #(.LANES(L)) u0 (
        .clk(clk), .rst_n(rst_n), .cut_out(cut_out), .cap_en(cap_en),
        .upd_en(upd_en), .det_en(det_en), .mode_le(mode_le),
        .err_clr(err_clr), .mode_o(mode_o), .err_o(err_o), .fault_o(fault_o)
    );

    // {clr, le, cap, upd, det, out[3:0], exp_mode[3:0], exp_err[3:0]}
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        17'b1_0_0_0_0_0000_0000_0000, // R5 clear
        17'b0_0_1_0_0_1010_0000_0000, // sq low captured
        17'b0_1_0_1_0_1011_0001_0000, // R2 lane0 sensitized, R6
        17'b0_0_1_1_0_1010_0001_0000, // prime, R7 R3
        17'b0_0_1_1_1_1011_0001_0000, // R4 no diff yet
        17'b0_0_1_1_1_1110_0001_0001, // lane2 glitch at edge
        17'b0_0_1_1_1_1011_0001_0101, // R4 lane2 set, R10
        17'b0_0_1_1_1_1010_0001_0101, // R4 sticky
        17'b0_0_1_1_1_1011_0001_0101, // R8 lane2 fault only
        17'b1_0_1_1_1_1010_0001_0000, // R5 priority over set
        17'b0_1_1_1_1_1011_0001_0000, // R6 blocked
        17'b0_0_1_1_0_1010_0001_0000, // R7 unarmed
        17'b0_1_0_0_0_1000_0010_0000, // R2 lane0 cleared, lane1 set
        17'b0_0_1_1_1_1000_0010_0001  // R8 lane0 now faults, R3
    };

    task automatic chk(string tag, logic [L-1:0] act, logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(logic c, logic le, logic cp, logic up, logic d, logic [L-1:0] o);
        @(negedge clk);
        err_clr = c; mode_le = le; cap_en = cp; upd_en = up; det_en = d; cut_out = o;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1;
        chk("R1 mode", mode_o, '0);
        chk("R1 err", err_o, '0);
        chk("R1 fault", fault_o, '0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][16], VEC[k][15], VEC[k][14], VEC[k][13], VEC[k][12], VEC[k][11:8]);
            chk("R2/R3 mode", mode_o, VEC[k][7:4]);
            chk("R4-R7 err", err_o, VEC[k][3:0]);
            chk("R8 fault", fault_o, VEC[k][3:0] & ~VEC[k][7:4]);
        end
        // R9: pulses between edges are not registered
        step(1, 0, 0, 0, 0, 4'b0000);
        step(0, 0, 1, 1, 0, 4'b0000);
        step(0, 0, 1, 1, 0, 4'b0000);
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 1, 1, 1, 4'b0000);
            #0.5 cut_out = 4'b1100;
            #1   cut_out = 4'b0000;
        end
        step(0, 0, 1, 1, 1, 4'b0000);
        chk("R9 err", err_o, 4'b0000);
        // R4/R10: edge glitch on lane3 only
        step(0, 0, 1, 1, 1, 4'b1000);
        step(0, 0, 1, 1, 1, 4'b0000);
        chk("R4 lane3 err", err_o, 4'b1000);
        chk("R8 lane3 fault", fault_o, 4'b1000);
        chk("R3 mode kept", mode_o, 4'b0010);
        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mode mid", mode_o, '0);
        chk("R1 err mid", err_o, '0);
        chk("R1 fault mid", fault_o, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule